// File: doc/BRIEF.md
# Concurrent Write Collision Resolver

This block holds a single shared storage word that many processing elements can write in the same clock cycle. Each of `NREQ` requesters has a write-enable bit and a data word. When only one requester writes, its value is stored. When two or more write together, a resolution policy chosen at run time picks the stored value. The policies are: priority to the lowest index, bitwise OR of all written values, largest unsigned value, or exclusive-write, where a collision is treated as an error.

OR mode supports a one-step parallel search. Every requester writes its one-bit match flag, and the stored word becomes 1 exactly when some requester found a match. Exclusive-write mode enforces the rule that at most one writer may act per cycle. A breach leaves the word as it was and sets a sticky error flag, which software clears with a pulse. All `NRD` read ports return the registered word at the same time.

The write side has no back-pressure. Every request is taken in the cycle it is presented, because the resolver always finishes in that cycle and updates the word on the following clock edge. Control pins (mode, error clear) and status pins (collision, error) are plain levels. `NREQ` must be a power of two.

Top module: `cwr_shared_word`

## Requirements
- R1: While reset is low, and after it is released until the first write, the stored word, every read port, `collision` and `err_flag` are all zero.
- R2: When exactly one `wr_en` bit is set, the stored word takes that requester's data on the next rising edge, in every mode.
- R3: When no `wr_en` bit is set, the stored word keeps its value.
- R4: In mode 0 (priority), on a collision the stored word takes the data of the enabled requester with the lowest index.
- R5: In mode 1 (OR), on a collision the stored word becomes the bitwise OR of the enabled requesters' data. Data on disabled requesters has no effect.
- R6: In mode 2 (largest), on a collision the stored word becomes the largest unsigned data value among the enabled requesters.
- R7: In mode 3 (exclusive), on a collision the stored word is unchanged and `err_flag` is high from the next edge.
- R8: `err_flag` stays high until a cycle with `err_clr` high. In that same cycle, a new exclusive-mode collision takes priority, and the flag stays set.
- R9: `collision` is high in the cycle after any cycle with two or more `wr_en` bits set, in any mode. It is low after any other cycle.
- R10: Every read port presents the stored word. Requester i's data sits at bits [i*DW +: DW] of `wr_data`, and read port j at bits [j*DW +: DW] of `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Resolution policy: 0 priority, 1 OR, 2 largest, 3 exclusive |
| wr_en | input | NREQ | Per-requester write enable |
| wr_data | input | NREQ*DW | Packed per-requester write data |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_data | output | NRD*DW | Packed read ports, each the stored word |
| collision | output | 1 | Two or more writers in the previous cycle |
| err_flag | output | 1 | Sticky exclusive-write violation |

## Verification
The bench drives all 16 write-enable patterns of four requesters in each of the four modes. It repeats this over eight data sets, so ties, zero values and the all-ones value all occur. The empty pattern and the one-hot patterns separate hold and single-writer behaviour from collision handling. The multi-bit patterns separate the policies from one another: the lowest-index result differs from the largest value, and the OR differs from both whenever the bits spread. The error-clear pulse is cycled independently of the vectors, so it lands both on idle cycles and on exclusive-mode collisions.

// File: rtl/cwr_pkg.sv
package cwr_pkg;
  typedef enum logic [1:0] {
    CW_FIRST = 2'd0,
    CW_OR    = 2'd1,
    CW_MAX   = 2'd2,
    CW_EXCL  = 2'd3
  } cw_mode_e;
endpackage

// File: rtl/cwr_prio_pick.sv
// Selects the data of the lowest-index enabled requester.
module cwr_prio_pick #(
  parameter int NREQ = 4,
  parameter int DW   = 8
) (
  input  logic [NREQ-1:0]    en,
  input  logic [NREQ*DW-1:0] din,
  output logic [DW-1:0]      dout
);
  logic [NREQ-1:0] seen;
  logic [NREQ-1:0] hit;

  for (genvar i = 0; i < NREQ; i++) begin : g_chain
    if (i == 0) begin : g_first
      assign seen[i] = 1'b0;
    end else begin : g_rest
      assign seen[i] = seen[i-1] | en[i-1];
    end
    assign hit[i] = en[i] & ~seen[i];
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NREQ; i++) begin
      if (hit[i]) dout = dout | din[i*DW +: DW];
    end
  end
endmodule

// File: rtl/cwr_or_merge.sv
// Bitwise OR of all enabled requesters' data.
module cwr_or_merge #(
  parameter int NREQ = 4,
  parameter int DW   = 8
) (
  input  logic [NREQ-1:0]    en,
  input  logic [NREQ*DW-1:0] din,
  output logic [DW-1:0]      dout
);
  logic [NREQ*DW-1:0] masked;

  for (genvar i = 0; i < NREQ; i++) begin : g_mask
    assign masked[i*DW +: DW] = din[i*DW +: DW] & {DW{en[i]}};
  end

  always_comb begin
    dout = '0;
    for (int i = 0; i < NREQ; i++) dout = dout | masked[i*DW +: DW];
  end
endmodule

// File: rtl/cwr_max_tree.sv
// Balanced comparator tree picking the largest enabled value.
// Heap layout: node k has children 2k+1 and 2k+2, leaves start at NREQ-1.
module cwr_max_tree #(
  parameter int NREQ = 4,
  parameter int DW   = 8
) (
  input  logic [NREQ-1:0]    en,
  input  logic [NREQ*DW-1:0] din,
  output logic [DW-1:0]      dout
);
  localparam int NODES = 2 * NREQ - 1;

  logic [DW-1:0] nv  [NODES];
  logic          nok [NODES];

  for (genvar i = 0; i < NREQ; i++) begin : g_leaf
    assign nv[NREQ-1+i]  = din[i*DW +: DW];
    assign nok[NREQ-1+i] = en[i];
  end

  for (genvar k = 0; k < NREQ - 1; k++) begin : g_node
    logic take_r;
    assign take_r = nok[2*k+2] && (!nok[2*k+1] || (nv[2*k+2] > nv[2*k+1]));
    assign nv[k]  = take_r ? nv[2*k+2] : nv[2*k+1];
    assign nok[k] = nok[2*k+1] | nok[2*k+2];
  end

  assign dout = nok[0] ? nv[0] : '0;
endmodule

// File: rtl/cwr_shared_word.sv
module cwr_shared_word
  import cwr_pkg::*;
#(
  parameter int NREQ = 8,
  parameter int DW   = 8,
  parameter int NRD  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [NREQ-1:0]   wr_en,
  input  logic [NREQ*DW-1:0] wr_data,
  input  logic              err_clr,
  output logic [NRD*DW-1:0] rd_data,
  output logic              collision,
  output logic              err_flag
);
  cw_mode_e      mode_e;
  logic [DW-1:0] first_val, or_val, max_val;
  logic [DW-1:0] word_q, word_d;
  logic          any_wr, multi, err_set;
  logic          coll_q, err_q;

  assign mode_e = cw_mode_e'(mode);
  assign any_wr = |wr_en;
  // two or more bits set: clearing the lowest set bit leaves something
  assign multi  = |(wr_en & (wr_en - 1'b1));

  cwr_prio_pick #(.NREQ(NREQ), .DW(DW)) u_pick (
    .en(wr_en), .din(wr_data), .dout(first_val));
  cwr_or_merge  #(.NREQ(NREQ), .DW(DW)) u_or (
    .en(wr_en), .din(wr_data), .dout(or_val));
  cwr_max_tree  #(.NREQ(NREQ), .DW(DW)) u_max (
    .en(wr_en), .din(wr_data), .dout(max_val));

  always_comb begin
    word_d = word_q;
    if (any_wr) begin
      if (!multi) begin
        word_d = first_val;
      end else begin
        unique case (mode_e)
          CW_FIRST: word_d = first_val;
          CW_OR:    word_d = or_val;
          CW_MAX:   word_d = max_val;
          CW_EXCL:  word_d = word_q;
          default:  word_d = word_q;
        endcase
      end
    end
  end

  assign err_set = multi && (mode_e == CW_EXCL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      coll_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      word_q <= word_d;
      coll_q <= multi;
      err_q  <= err_set | (err_q & ~err_clr);
    end
  end

  for (genvar j = 0; j < NRD; j++) begin : g_rd
    assign rd_data[j*DW +: DW] = word_q;
  end

  assign collision = coll_q;
  assign err_flag  = err_q;

  // R2: a lone writer lands its data
  p_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(wr_en) |=> word_q == $past(first_val));
  // R3: idle cycles hold the word
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en == '0) |=> $stable(word_q));
  // R6: largest-value policy
  p_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && mode_e == CW_MAX) |=> word_q == $past(max_val));
  // R7: exclusive breach keeps the word and raises the flag
  p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (multi && mode_e == CW_EXCL) |=> ($stable(word_q) && err_flag));
  // R8: flag is sticky without a clear
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !err_clr) |=> err_flag);
  // R9: collision report follows the enable count
  p_coll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) > 1) |=> collision);
  p_nocoll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) < 2) |=> !collision);
endmodule

// File: tb/test_cwr_shared_word.sv
module test_cwr_shared_word;
  localparam int NREQ = 4;
  localparam int DW   = 4;
  localparam int NRD  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        mode = '0;
  logic [NREQ-1:0]   wr_en = '0;
  logic [NREQ*DW-1:0] wr_data = '0;
  logic              err_clr = 1'b0;
  logic [NRD*DW-1:0] rd_data;
  logic              collision;
  logic              err_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  cwr_shared_word #(.NREQ(NREQ), .DW(DW), .NRD(NRD)) i_cwr_shared_word (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wr_en(wr_en), .wr_data(wr_data),
    .err_clr(err_clr), .rd_data(rd_data), .collision(collision),
    .err_flag(err_flag));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int exp_word;
    bit exp_err;
    int k;
    exp_word = 0;
    exp_err  = 1'b0;
    k = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 word", int'(rd_data[DW-1:0]), 0);
    check("R1 collision", int'(collision), 0);
    check("R1 err_flag", int'(err_flag), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after release", int'(rd_data[DW-1:0]), 0);

    for (int seed = 0; seed < 8; seed++) begin
      for (int m = 0; m < 4; m++) begin
        for (int e = 0; e < 16; e++) begin
          int d [NREQ];
          int cnt, lo, orv, mx;
          bit clr;
          string tag;
          cnt = 0; lo = -1; orv = 0; mx = 0;
          for (int i = 0; i < NREQ; i++) begin
            d[i] = (seed * 7 + i * 5 + 3 + seed * i * 3) % 16;
            if (seed == 7) d[i] = (i == 2) ? 15 : 0;
            wr_data[i*DW +: DW] = DW'(d[i]);
            if (e[i]) begin
              cnt++;
              if (lo < 0) lo = d[i];
              orv = orv | d[i];
              if (d[i] > mx) mx = d[i];
            end
          end
          clr = (k % 3 == 0);
          k++;
          mode = 2'(m);
          wr_en = 4'(e);
          err_clr = clr;
          if (cnt == 0) tag = "R3";
          else if (cnt == 1) tag = "R2";
          else if (m == 0) tag = "R4";
          else if (m == 1) tag = "R5";
          else if (m == 2) tag = "R6";
          else tag = "R7";
          if (cnt == 1) exp_word = lo;
          else if (cnt > 1) begin
            if (m == 0) exp_word = lo;
            else if (m == 1) exp_word = orv;
            else if (m == 2) exp_word = mx;
          end
          if (cnt > 1 && m == 3) exp_err = 1'b1;
          else if (clr) exp_err = 1'b0;
          @(posedge clk);
          @(negedge clk);
          check($sformatf("%s word mode=%0d en=%0d", tag, m, e),
                int'(rd_data[DW-1:0]), exp_word);
          check("R10 second read port", int'(rd_data[DW +: DW]), exp_word);
          check("R9 collision", int'(collision), int'(cnt > 1));
          check((m == 3 && cnt > 1) ? "R7 err_flag" : "R8 err_flag",
                int'(err_flag), int'(exp_err));
        end
      end
    end
    wr_en = '0;
    err_clr = 1'b0;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule